// File: doc/BRIEF.md
# Privileged Instruction Trap Decoder

This block sits in the decode or execute stage of a processor core that implements a supervisor mode and hypervisor-style virtualization. For a small group of privileged instructions (wait-for-interrupt, wait-on-reservation without timeout, the supervisor address-translation fence, the two hypervisor address-translation fences, and the hypervisor guest load/store and guest execute-read instructions) it decides whether the instruction may proceed, must raise an illegal-instruction trap, or must raise a virtual-instruction trap. The decision is based on the current privilege level, the virtualization flag, whether the core has a supervisor mode at all, and a handful of trap-control status bits.

The verdict is a one-hot triple of execute, illegal and virtual-fault. For the hypervisor guest access classes the block also produces the access mode that the memory pipeline should use for the guest translation. The flush, halt and memory actions that follow an execute verdict are performed elsewhere. A parameter selects whether the result is registered (one cycle of latency) or passed straight through.

Top module: `priv_trap_decoder`

## Requirements
- R1: For every request with `req_valid_i` high the outputs `exec_o`, `illegal_o` and `vfault_o` have exactly one bit set; with `valid_o` low all three and `mode_o` are zero. Privilege encoding: 0 user, 1 supervisor, 3 machine; opcode classes: 0 wait-for-interrupt, 1 wait-on-reservation, 2 supervisor fence, 3 hypervisor guest-virtual fence, 4 hypervisor guest-physical fence, 5 guest load/store, 6 guest execute-read, 7 reserved.
- R2: Wait-for-interrupt is illegal when the timeout-wait bit `tw_i` is set and the privilege is supervisor, or is user on a core without supervisor mode; it is also illegal at user privilege without virtualization on a core that has supervisor mode.
- R3: A wait-for-interrupt that is not illegal raises a virtual fault when virtualized and the privilege is user, or is supervisor with `vtw_i` set; otherwise it executes.
- R4: Wait-on-reservation raises a virtual fault when virtualized at supervisor or user with `vtw_i` set and `tw_i` clear; otherwise it is illegal at any privilege except machine when `tw_i` is set; otherwise it executes.
- R5: The supervisor fence is illegal without virtualization at user privilege or at supervisor with `tvm_i` set; with virtualization it raises a virtual fault at user privilege or when `vtvm_i` is set; otherwise it executes.
- R6: The hypervisor guest-virtual fence raises a virtual fault whenever virtualized; otherwise it executes at machine or supervisor and is illegal at user.
- R7: The hypervisor guest-physical fence is illegal at non-virtualized supervisor with `tvm_i` set; otherwise it follows R6.
- R8: Guest load/store and guest execute-read always execute at machine privilege; elsewhere they raise a virtual fault when virtualized, are illegal at user with `hu_i` clear, and otherwise execute.
- R9: For classes 5 and 6 `mode_o[2]` (two-stage tag) is 1 and `mode_o[1:0]` is 0 when `spvp_i` is clear, 2 when `spvp_i` is set and the class is 5 with `vsum_i` set, and 1 otherwise; for all other classes `mode_o` is zero.
- R10: With `REG_OUT`=1 a request presented before a rising edge appears on the outputs after that edge and not before; a cycle with `req_valid_i` low yields all-zero outputs after the next edge, and reset clears every output.
- R11: The reserved opcode class 7 is always illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| op_i | input | 3 | Instruction class |
| priv_i | input | 2 | Current privilege level |
| virt_i | input | 1 | Hart is running virtualized |
| has_smode_i | input | 1 | Core implements supervisor mode |
| tw_i | input | 1 | Timeout-wait trap control |
| tvm_i | input | 1 | Trap translation management at supervisor |
| vtw_i | input | 1 | Virtual timeout-wait trap control |
| vtvm_i | input | 1 | Virtual trap translation management |
| hu_i | input | 1 | Guest access allowed at user privilege |
| spvp_i | input | 1 | Guest access privilege (1 = supervisor) |
| vsum_i | input | 1 | Guest supervisor may touch user pages |
| valid_o | output | 1 | Verdict valid |
| exec_o | output | 1 | Instruction may execute |
| illegal_o | output | 1 | Raise illegal-instruction trap |
| vfault_o | output | 1 | Raise virtual-instruction trap |
| mode_o | output | 3 | Guest access mode (bit 2 two-stage tag) |

## Verification
The bench sweeps every class against every legal privilege, both virtualization states, both supervisor-presence settings and all seven status bits, so the overlap cases are all reached: a wait-for-interrupt at user privilege on a core without supervisor mode, a wait-on-reservation with both `tw_i` and `vtw_i` set, and a guest-physical fence at supervisor with `tvm_i` set. A design that checked the virtual fault before the illegal condition would report virtual faults where illegal is owed, and one that ignored supervisor presence would trap user-mode waits on small cores with the wrong cause. The execute-read class is compared against the load/store class with `vsum_i` set to catch a mode encoder that applies the user-page relaxation to execute accesses, and the idle and latency checks catch a stale verdict held past a bubble.

// File: rtl/ptd_pkg.sv
package ptd_pkg;
  localparam int OP_W   = 3;
  localparam int PRIV_W = 2;
  localparam int MODE_W = 3;
  localparam int ACT_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_WFI    = 3'd0,
    OP_WRS    = 3'd1,
    OP_SFENCE = 3'd2,
    OP_HFV    = 3'd3,
    OP_HFG    = 3'd4,
    OP_HLS    = 3'd5,
    OP_HLX    = 3'd6,
    OP_RSV    = 3'd7
  } op_e;

  typedef enum logic [PRIV_W-1:0] {
    PRV_U = 2'd0,
    PRV_S = 2'd1,
    PRV_R = 2'd2,
    PRV_M = 2'd3
  } priv_e;

  typedef struct packed {
    logic illegal;
    logic vfault;
  } verdict_t;
endpackage

// File: rtl/ptd_wait_rules.sv
module ptd_wait_rules
  import ptd_pkg::*;
(
  input  op_e      op,
  input  priv_e    priv,
  input  logic     virt,
  input  logic     has_s,
  input  logic     tw,
  input  logic     vtw,
  output verdict_t verdict
);
  logic is_u, is_s, is_m;
  logic wfi_ill, wfi_vf, wrs_ill, wrs_vf;

  assign is_u = (priv == PRV_U);
  assign is_s = (priv == PRV_S);
  assign is_m = (priv == PRV_M);

  always_comb begin
    // wait-for-interrupt: illegal causes win over the virtual fault
    wfi_ill = ((is_s || (!has_s && is_u)) && tw) || (has_s && is_u && !virt);
    wfi_vf  = !wfi_ill && virt && (is_u || (is_s && vtw));
    // wait-on-reservation: virtual fault is tested first
    wrs_vf  = virt && (is_s || is_u) && vtw && !tw;
    wrs_ill = !wrs_vf && !is_m && tw;

    verdict = '0;
    if (op == OP_WFI) verdict = '{illegal: wfi_ill, vfault: wfi_vf};
    if (op == OP_WRS) verdict = '{illegal: wrs_ill, vfault: wrs_vf};
  end

  // R4: a reservation-wait virtual fault needs vtw set and tw clear
  always_comb begin
    if (op == OP_WRS && verdict.vfault)
      a_r4_wrs_vfault_cause : assert (vtw && !tw && virt);
  end
endmodule

// File: rtl/ptd_fence_rules.sv
module ptd_fence_rules
  import ptd_pkg::*;
(
  input  op_e      op,
  input  priv_e    priv,
  input  logic     virt,
  input  logic     tvm,
  input  logic     vtvm,
  output verdict_t verdict
);
  logic is_u, is_s, is_m;
  logic sf_ill, sf_vf, hv_ill, hv_vf, hg_tvm;

  assign is_u = (priv == PRV_U);
  assign is_s = (priv == PRV_S);
  assign is_m = (priv == PRV_M);

  always_comb begin
    sf_ill = !virt && (is_u || (is_s && tvm));
    sf_vf  = !sf_ill && virt && (is_u || vtvm);
    hv_vf  = virt;
    hv_ill = !virt && !(is_m || is_s);
    hg_tvm = is_s && !virt && tvm;

    unique case (op)
      OP_SFENCE: verdict = '{illegal: sf_ill, vfault: sf_vf};
      OP_HFV:    verdict = '{illegal: hv_ill, vfault: hv_vf};
      OP_HFG:    verdict = '{illegal: hg_tvm || hv_ill, vfault: !hg_tvm && hv_vf};
      default:   verdict = '0;
    endcase
  end

  // R6: hypervisor fences always fault virtually under virtualization
  always_comb begin
    if ((op == OP_HFV || op == OP_HFG) && virt)
      a_r6_hfence_virt : assert (verdict.vfault && !verdict.illegal);
  end
endmodule

// File: rtl/ptd_hyp_access.sv
module ptd_hyp_access
  import ptd_pkg::*;
(
  input  op_e               op,
  input  priv_e             priv,
  input  logic              virt,
  input  logic              hu,
  input  logic              spvp,
  input  logic              vsum,
  output verdict_t          verdict,
  output logic [MODE_W-1:0] mode
);
  localparam logic [MODE_W-2:0] M_USER  = 2'd0;
  localparam logic [MODE_W-2:0] M_SUPV  = 2'd1;
  localparam logic [MODE_W-2:0] M_SUPVU = 2'd2;

  logic is_hyp;
  logic [MODE_W-2:0] base;

  assign is_hyp = (op == OP_HLS) || (op == OP_HLX);

  always_comb begin
    verdict = '0;
    if (is_hyp && priv != PRV_M) begin
      if (virt)                          verdict.vfault  = 1'b1;
      else if (priv == PRV_U && !hu)     verdict.illegal = 1'b1;
    end
  end

  always_comb begin
    if (!spvp)                       base = M_USER;
    else if (op == OP_HLS && vsum)   base = M_SUPVU;
    else                             base = M_SUPV;
    mode = is_hyp ? {1'b1, base} : '0;
  end

  // R8: machine privilege never traps a guest access
  always_comb begin
    if (is_hyp && priv == PRV_M)
      a_r8_machine_allowed : assert (!verdict.illegal && !verdict.vfault);
  end
endmodule

// File: rtl/priv_trap_decoder.sv
module priv_trap_decoder
  import ptd_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              virt_i,
  input  logic              has_smode_i,
  input  logic              tw_i,
  input  logic              tvm_i,
  input  logic              vtw_i,
  input  logic              vtvm_i,
  input  logic              hu_i,
  input  logic              spvp_i,
  input  logic              vsum_i,
  output logic              valid_o,
  output logic              exec_o,
  output logic              illegal_o,
  output logic              vfault_o,
  output logic [MODE_W-1:0] mode_o
);
  op_e      op;
  priv_e    priv;
  verdict_t v_wait, v_fence, v_hyp, v_all;
  logic [MODE_W-1:0] mode_n;
  logic [ACT_W-1:0]  act_n;
  logic              valid_int;
  logic [ACT_W-1:0]  act_int;
  logic [MODE_W-1:0] mode_int;

  assign op   = op_e'(op_i);
  assign priv = priv_e'(priv_i);

  ptd_wait_rules u_wait (
    .op(op), .priv(priv), .virt(virt_i), .has_s(has_smode_i),
    .tw(tw_i), .vtw(vtw_i), .verdict(v_wait)
  );

  ptd_fence_rules u_fence (
    .op(op), .priv(priv), .virt(virt_i), .tvm(tvm_i),
    .vtvm(vtvm_i), .verdict(v_fence)
  );

  ptd_hyp_access u_hyp (
    .op(op), .priv(priv), .virt(virt_i), .hu(hu_i), .spvp(spvp_i),
    .vsum(vsum_i), .verdict(v_hyp), .mode(mode_n)
  );

  always_comb begin
    v_all = v_wait | v_fence | v_hyp;
    if (op == OP_RSV) v_all = '{illegal: 1'b1, vfault: 1'b0};
    act_n = {!v_all.illegal && !v_all.vfault, v_all.illegal, v_all.vfault};
  end

  generate
    if (REG_OUT) begin : g_reg
      logic              valid_q;
      logic [ACT_W-1:0]  act_q, act_d;
      logic [MODE_W-1:0] mode_q, mode_d;

      always_comb begin
        act_d  = act_q;
        mode_d = mode_q;
        if (req_valid_i) begin
          act_d  = act_n;
          mode_d = mode_n;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid_q <= 1'b0;
          act_q   <= '0;
          mode_q  <= '0;
        end else begin
          valid_q <= req_valid_i;
          act_q   <= act_d;
          mode_q  <= mode_d;
        end
      end

      assign valid_int = valid_q;
      assign act_int   = act_q;
      assign mode_int  = mode_q;
    end else begin : g_comb
      assign valid_int = req_valid_i;
      assign act_int   = act_n;
      assign mode_int  = mode_n;
    end
  endgenerate

  assign valid_o   = valid_int;
  assign exec_o    = valid_int & act_int[2];
  assign illegal_o = valid_int & act_int[1];
  assign vfault_o  = valid_int & act_int[0];
  assign mode_o    = valid_int ? mode_int : '0;

  a_r1_onehot : assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $onehot({exec_o, illegal_o, vfault_o}));

  a_r1_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ({exec_o, illegal_o, vfault_o} == '0 && mode_o == '0));

  a_r9_two_stage_tag : assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != '0) |-> (mode_o[MODE_W-1] && mode_o[MODE_W-2:0] != 2'd3));
endmodule

// File: tb/tb_priv_trap_decoder.sv
`timescale 1ns/1ps
module tb_priv_trap_decoder;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid_i;
  logic [2:0] op_i;
  logic [1:0] priv_i;
  logic virt_i, has_smode_i, tw_i, tvm_i, vtw_i, vtvm_i, hu_i, spvp_i, vsum_i;
  logic valid_o, exec_o, illegal_o, vfault_o;
  logic [2:0] mode_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  priv_trap_decoder dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .op_i(op_i),
    .priv_i(priv_i), .virt_i(virt_i), .has_smode_i(has_smode_i),
    .tw_i(tw_i), .tvm_i(tvm_i), .vtw_i(vtw_i), .vtvm_i(vtvm_i),
    .hu_i(hu_i), .spvp_i(spvp_i), .vsum_i(vsum_i), .valid_o(valid_o),
    .exec_o(exec_o), .illegal_o(illegal_o), .vfault_o(vfault_o),
    .mode_o(mode_o)
  );

  // expected {exec, illegal, vfault}, written from the requirement text
  function automatic logic [2:0] ref_act(input int op, input int pr, input bit vi,
      input bit hs, input bit tw, input bit tvm, input bit vtw, input bit vtvm, input bit hu);
    bit u = (pr == 0), s = (pr == 1), m = (pr == 3);
    case (op)
      0: begin // R2 then R3
        if ((tw && (s || (u && !hs))) || (u && hs && !vi)) return 3'b010;
        if (vi && (u || (s && vtw)))                         return 3'b001;
        return 3'b100;
      end
      1: begin // R4
        if (vi && (s || u) && vtw && !tw) return 3'b001;
        if (!m && tw)                     return 3'b010;
        return 3'b100;
      end
      2: begin // R5
        if (!vi && (u || (s && tvm))) return 3'b010;
        if (vi && (u || vtvm))        return 3'b001;
        return 3'b100;
      end
      3, 4: begin // R6, R7
        if (op == 4 && s && !vi && tvm) return 3'b010;
        if (vi)                         return 3'b001;
        if (m || s)                     return 3'b100;
        return 3'b010;
      end
      5, 6: begin // R8
        if (m)        return 3'b100;
        if (vi)       return 3'b001;
        if (u && !hu) return 3'b010;
        return 3'b100;
      end
      default: return 3'b010; // R11
    endcase
  endfunction

  function automatic logic [2:0] ref_mode(input int op, input bit spvp, input bit vsum);
    if (op != 5 && op != 6) return 3'd0;
    if (!spvp) return 3'b100;
    if (op == 5 && vsum) return 3'b110;
    return 3'b101;
  endfunction

  function automatic string act_tag(input int op, input logic [2:0] e);
    case (op)
      0: return e[1] ? "R2" : "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5, 6: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h (op=%0d priv=%0d virt=%0b)",
               req, act, exp, op_i, priv_i, virt_i);
    end
  endtask

  task automatic drive(input bit vld, input int op, input int pr, input logic [8:0] f);
    req_valid_i = vld;
    op_i        = 3'(op);
    priv_i      = 2'(pr);
    {virt_i, has_smode_i, tw_i, tvm_i, vtw_i, vtvm_i, hu_i, spvp_i, vsum_i} = f;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b1, 2, 0, 9'h000);
    repeat (3) @(negedge clk);
    // R10: reset holds every output at zero even with a request pending
    check("R10", {4'd0, valid_o, exec_o, illegal_o, vfault_o}, 8'h00);
    check("R10", {5'd0, mode_o}, 8'h00);
    drive(1'b0, 0, 0, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle cycle gives all-zero outputs
    check("R1", {4'd0, valid_o, exec_o, illegal_o, vfault_o}, 8'h00);

    // exhaustive sweep; each request is checked one edge later
    for (int op = 0; op < 8; op++) begin
      for (int pi = 0; pi < 3; pi++) begin
        for (int f = 0; f < 512; f++) begin
          automatic int pr = (pi == 2) ? 3 : pi;
          automatic logic [8:0] fl = 9'(f);
          automatic logic [2:0] ea;
          automatic logic [2:0] em;
          drive(1'b1, op, pr, fl);
          ea = ref_act(op, pr, fl[8], fl[7], fl[6], fl[5], fl[4], fl[3], fl[2]);
          em = ref_mode(op, fl[1], fl[0]);
          @(negedge clk);
          check(act_tag(op, ea), {5'd0, exec_o, illegal_o, vfault_o}, {5'd0, ea});
          check("R1", {7'd0, valid_o && $onehot({exec_o, illegal_o, vfault_o})}, 8'd1);
          check("R9", {5'd0, mode_o}, {5'd0, em});
        end
      end
    end

    // R10: new request is not visible before the edge
    drive(1'b1, 6, 3, 9'h003);          // guest execute-read at machine, spvp, vsum
    @(negedge clk);
    check("R9", {5'd0, mode_o}, 8'h05);  // execute access ignores vsum
    drive(1'b1, 5, 0, 9'h003);          // guest load at user, hu clear -> illegal
    #1;
    check("R10", {5'd0, exec_o, illegal_o, vfault_o}, 8'h04);
    @(negedge clk);
    check("R8", {5'd0, exec_o, illegal_o, vfault_o}, 8'h02);
    // R10: a bubble clears the outputs after the next edge
    drive(1'b0, 7, 1, 9'h1FF);
    @(negedge clk);
    check("R10", {4'd0, valid_o, exec_o, illegal_o, vfault_o}, 8'h00);
    check("R10", {5'd0, mode_o}, 8'h00);
    drive(1'b1, 7, 3, 9'h000);
    @(negedge clk);
    check("R11", {5'd0, exec_o, illegal_o, vfault_o}, 8'h02);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule